// File: doc/BRIEF.md
# Memory-resident register operand fetch sequencer

This block fetches one source operand for a processor whose general registers live in main memory rather than in flip-flops. Register n of the current context sits at the context base pointer plus 2n. On a start pulse the block takes a base pointer, a register index, an addressing mode and an operand size. It then runs a fixed series of memory steps over a single-port request/ready bus and returns the operand with a one-cycle done pulse.

Three addressing modes are handled. Direct mode uses the register contents themselves as the operand. Indirect mode uses the register contents as an address. The post-increment mode also advances the register by the operand size. In that mode the advanced register value is written back before the operand is read. A register that holds its own address therefore yields its own already-advanced value.

Sizes are byte, word and double word. A double word occupies two consecutive memory words. When it starts at the last register, its second half comes from the word just past the register area.

Top module: `wsreg_fetch`

## Requirements
- R1: The memory address of register n is base + 2n, computed modulo 2^16 (base 0xFFF0, register 10 gives address 0x0004).
- R2: The mode input encodes 0 as direct, 1 as indirect and 2 as post-increment; 3 behaves as indirect. In direct mode with size word, the block performs exactly one read, at the register address, and no write. It returns the register contents zero-extended to 32 bits.
- R3: In indirect mode the block reads the register, then reads the operand at that register's contents, and issues no write; the register keeps its value.
- R4: In post-increment mode the bus sequence is: read register, write register with (read value + increment), then read the operand at the value first read.
- R5: With base 0x8300 and register 0 holding 0x8300, a post-increment word fetch through register 0 returns 0x8302 and leaves 0x8302 in register 0.
- R6: The size input encodes 0 as byte, 1 as word and 2 as double word; 3 behaves as word. The post-increment amount is 1 for byte, 2 for word and 4 for double word.
- R7: A byte operand is read from the aligned word. An even address selects bits 15:8 and an odd address selects bits 7:0, zero-extended to 32 bits.
- R8: A double word is read as two words at A and A+2, and the operand is {first, second}. In direct mode starting at register 15, the second word is at base+32 with no wrap to register 0 (0x0000 then 0x1000 gives 0x00001000).
- R9: A request holds its address, write enable and write data unchanged until ready is seen; every step waits on ready. A word post-increment fetch with L wait cycles per access completes 3(L+1) cycles after the start edge.
- R10: Done is high for exactly one cycle with the operand valid. The operand holds until the next fetch changes it, and a start while busy is ignored.
- R11: During reset the request, done and busy outputs are low and the operand is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fetch (taken only when idle) |
| mode | input | 2 | Addressing mode (R2 encoding) |
| size | input | 2 | Operand size (R6 encoding) |
| reg_idx | input | 4 | Register number |
| wp | input | 16 | Base address of the register area |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle pulse, operand valid |
| operand | output | 32 | Fetched operand |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Even byte address of the word accessed |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid when ready is high |
| mem_ready | input | 1 | Completes the current request |

## Verification
The fetch is driven through every mode with register contents that point into separate memory regions. A register whose contents equal its own address is the pattern that tells a write-back-first ordering apart from a read-first one, because only then does the operand read land on the register just written. Odd and even byte pointers separate the two byte lanes and the increment of 1 from that of 2. A double word starting at register 15, with a known value just past the register area, shows whether the second address carries past the area or wraps, and wait states of zero and three show that every step is gated by ready.

// File: rtl/wsreg_pkg.sv
package wsreg_pkg;
  localparam int WORD_W = 16;
  localparam int IDX_W  = 4;
  localparam int BYTE_W = WORD_W / 2;
  localparam int OPND_W = 2 * WORD_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    AM_DIRECT   = 2'd0,
    AM_INDIRECT = 2'd1,
    AM_AUTOINC  = 2'd2,
    AM_RSVD     = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } osize_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REG_RD, ST_REG_RD2, ST_REG_WB, ST_OP_RD, ST_OP_RD2, ST_DONE
  } step_e;

  typedef enum logic [1:0] {
    CAP_NONE, CAP_SINGLE, CAP_HI, CAP_LO
  } cap_e;

  // Address of register n inside the register area, 16-bit wraparound.
  function automatic word_t reg_slot(word_t base, logic [IDX_W-1:0] n);
    return base + word_t'({n, 1'b0});
  endfunction

  // Post-increment amount for each operand size.
  function automatic word_t ptr_step(osize_e sz);
    case (sz)
      SZ_BYTE:  return word_t'(1);
      SZ_DWORD: return word_t'(4);
      default:  return word_t'(2);
    endcase
  endfunction

  function automatic word_t align_word(word_t a);
    return {a[WORD_W-1:1], 1'b0};
  endfunction

  // Even byte address -> upper lane, odd -> lower lane.
  function automatic logic [BYTE_W-1:0] lane_pick(word_t w, logic odd);
    return odd ? w[BYTE_W-1:0] : w[WORD_W-1:BYTE_W];
  endfunction
endpackage

// File: rtl/wsreg_addr.sv
module wsreg_addr
  import wsreg_pkg::*;
(
  input  step_e                step,
  input  word_t                wp_q,
  input  logic [IDX_W-1:0]     idx_q,
  input  word_t                ptr_q,
  input  osize_e               size_q,
  output word_t                addr,
  output word_t                wdata,
  output logic                 we
);
  word_t slot;
  word_t opa;

  assign slot = reg_slot(wp_q, idx_q);
  assign opa  = align_word(ptr_q);

  always_comb begin
    addr  = '0;
    wdata = '0;
    we    = 1'b0;
    case (step)
      ST_REG_RD:  addr = slot;
      ST_REG_RD2: addr = slot + word_t'(2);
      ST_REG_WB: begin
        addr  = slot;
        we    = 1'b1;
        wdata = ptr_q + ptr_step(size_q);
      end
      ST_OP_RD:   addr = opa;
      ST_OP_RD2:  addr = opa + word_t'(2);
      default:    addr = '0;
    endcase
  end
endmodule

// File: rtl/wsreg_seq.sv
module wsreg_seq
  import wsreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [1:0]       size,
  input  logic [IDX_W-1:0] reg_idx,
  input  word_t            wp,
  input  logic             mem_ready,
  input  word_t            mem_rdata,
  output step_e            step,
  output word_t            wp_q,
  output logic [IDX_W-1:0] idx_q,
  output osize_e           size_q,
  output word_t            ptr_q,
  output cap_e             cap,
  output logic             lane_odd,
  output logic             mem_req,
  output logic             busy,
  output logic             done
);
  amode_e mode_q;
  step_e  nxt;
  logic   xfer;
  logic   accept;
  logic   wb_seen;

  assign mem_req = (step == ST_REG_RD) || (step == ST_REG_RD2) || (step == ST_REG_WB) ||
                   (step == ST_OP_RD)  || (step == ST_OP_RD2);
  assign xfer    = mem_req && mem_ready;
  assign accept  = start && (step == ST_IDLE);
  assign busy    = (step != ST_IDLE);
  assign done    = (step == ST_DONE);
  assign lane_odd = (mode_q == AM_DIRECT) ? 1'b0 : ptr_q[0];

  always_comb begin
    nxt = step;
    case (step)
      ST_IDLE:    if (start) nxt = ST_REG_RD;
      ST_REG_RD:
        if (xfer) begin
          if (mode_q == AM_DIRECT)       nxt = (size_q == SZ_DWORD) ? ST_REG_RD2 : ST_DONE;
          else if (mode_q == AM_AUTOINC) nxt = ST_REG_WB;
          else                           nxt = ST_OP_RD;
        end
      ST_REG_RD2: if (xfer) nxt = ST_DONE;
      ST_REG_WB:  if (xfer) nxt = ST_OP_RD;
      ST_OP_RD:   if (xfer) nxt = (size_q == SZ_DWORD) ? ST_OP_RD2 : ST_DONE;
      ST_OP_RD2:  if (xfer) nxt = ST_DONE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    cap = CAP_NONE;
    if (xfer) begin
      case (step)
        ST_REG_RD:
          if (mode_q == AM_DIRECT) cap = (size_q == SZ_DWORD) ? CAP_HI : CAP_SINGLE;
        ST_OP_RD:  cap = (size_q == SZ_DWORD) ? CAP_HI : CAP_SINGLE;
        ST_REG_RD2, ST_OP_RD2: cap = CAP_LO;
        default:   cap = CAP_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step    <= ST_IDLE;
      mode_q  <= AM_DIRECT;
      size_q  <= SZ_WORD;
      wp_q    <= '0;
      idx_q   <= '0;
      ptr_q   <= '0;
      wb_seen <= 1'b0;
    end else begin
      step <= nxt;
      if (accept) begin
        mode_q  <= (amode_e'(mode) == AM_RSVD) ? AM_INDIRECT : amode_e'(mode);
        size_q  <= (osize_e'(size) == SZ_RSVD) ? SZ_WORD : osize_e'(size);
        wp_q    <= wp;
        idx_q   <= reg_idx;
        wb_seen <= 1'b0;
      end
      if (xfer && step == ST_REG_RD && mode_q != AM_DIRECT) ptr_q <= mem_rdata;
      if (xfer && step == ST_REG_WB) wb_seen <= 1'b1;
    end
  end

  AST_WB_BEFORE_OPREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_OP_RD && mode_q == AM_AUTOINC) |-> wb_seen); // R4
  AST_WB_ONLY_AUTOINC: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_REG_WB) |-> (mode_q == AM_AUTOINC)); // R3
  AST_NO_OPREAD_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_OP_RD) |-> (mode_q != AM_DIRECT)); // R2
endmodule

// File: rtl/wsreg_capture.sv
module wsreg_capture
  import wsreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cap_e              cap,
  input  word_t             rdata,
  input  osize_e            size_q,
  input  logic              lane_odd,
  output logic [OPND_W-1:0] operand
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      operand <= '0;
    end else begin
      case (cap)
        CAP_SINGLE:
          if (size_q == SZ_BYTE) operand <= OPND_W'(lane_pick(rdata, lane_odd));
          else                   operand <= OPND_W'(rdata);
        CAP_HI:  operand <= {rdata, {WORD_W{1'b0}}};
        CAP_LO:  operand[WORD_W-1:0] <= rdata;
        default: operand <= operand;
      endcase
    end
  end
endmodule

// File: rtl/wsreg_fetch.sv
module wsreg_fetch
  import wsreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [1:0]        size,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [WORD_W-1:0] wp,
  output logic              busy,
  output logic              done,
  output logic [OPND_W-1:0] operand,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  step_e            step;
  word_t            wp_q;
  logic [IDX_W-1:0] idx_q;
  osize_e           size_q;
  word_t            ptr_q;
  cap_e             cap;
  logic             lane_odd;
  logic             we_step;

  wsreg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .size(size),
    .reg_idx(reg_idx), .wp(wp), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .step(step), .wp_q(wp_q), .idx_q(idx_q), .size_q(size_q), .ptr_q(ptr_q),
    .cap(cap), .lane_odd(lane_odd), .mem_req(mem_req), .busy(busy), .done(done)
  );

  wsreg_addr u_addr (
    .step(step), .wp_q(wp_q), .idx_q(idx_q), .ptr_q(ptr_q), .size_q(size_q),
    .addr(mem_addr), .wdata(mem_wdata), .we(we_step)
  );

  assign mem_we = mem_req && we_step;

  wsreg_capture u_cap (
    .clk(clk), .rst_n(rst_n), .cap(cap), .rdata(mem_rdata), .size_q(size_q),
    .lane_odd(lane_odd), .operand(operand)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req); // R10
  AST_OPERAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(operand)); // R10
  AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]); // R7
endmodule

// File: tb/sim_wsreg_fetch.sv
module sim_wsreg_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [1:0]  size = 2'd1;
  logic [3:0]  reg_idx = 4'd0;
  logic [15:0] wp = 16'h0;
  logic        busy, done, mem_req, mem_we;
  logic [31:0] operand;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready;

  always #2.5 clk = ~clk;

  wsreg_fetch u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .size(size),
    .reg_idx(reg_idx), .wp(wp), .busy(busy), .done(done), .operand(operand),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  // Memory model: 1024 words, indexed by address bits 10:1.
  logic [15:0] mem [0:1023];
  int          lat = 0;
  int          wcnt = 0;
  logic [15:0] log_addr [0:127];
  logic [15:0] log_data [0:127];
  logic        log_we   [0:127];
  int          log_n = 0;

  assign mem_ready = mem_req && (wcnt >= lat);
  assign mem_rdata = mem[mem_addr[10:1]];

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      wcnt <= 0;
      if (mem_we) mem[mem_addr[10:1]] <= mem_wdata;
      log_addr[log_n[6:0]] <= mem_addr;
      log_data[log_n[6:0]] <= mem_we ? mem_wdata : mem_rdata;
      log_we[log_n[6:0]]   <= mem_we;
      log_n <= log_n + 1;
    end else if (mem_req) begin
      wcnt <= wcnt + 1;
    end else begin
      wcnt <= 0;
    end
  end

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setw(input logic [15:0] a, input logic [15:0] d);
    mem[a[10:1]] = d;
  endtask

  function automatic logic [15:0] getw(input logic [15:0] a);
    return mem[a[10:1]];
  endfunction

  // Runs one fetch; cyc = negedges from the start edge until done is seen.
  task automatic run_op(input logic [1:0] m, input logic [1:0] s, input logic [3:0] r,
                        input logic [15:0] base, output int cyc, output int first);
    @(negedge clk);
    first = log_n;
    mode = m; size = s; reg_idx = r; wp = base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset;
    check("R11 req", {31'b0, mem_req}, 32'h0);
    check("R11 done", {31'b0, done}, 32'h0);
    check("R11 busy", {31'b0, busy}, 32'h0);
    check("R11 operand", operand, 32'h0);
  endtask

  task automatic t_direct_word;
    int c, f;
    setw(16'h8306, 16'h1234);
    run_op(2'd0, 2'd1, 4'd3, 16'h8300, c, f);
    check("R2 operand", operand, 32'h0000_1234);
    check("R2 access count", log_n - f, 1);
    check("R2 address", {16'h0, log_addr[f]}, 32'h0000_8306);
    check("R2 no write", {31'b0, log_we[f]}, 32'h0);
  endtask

  task automatic t_wrap;
    int c, f;
    setw(16'h0004, 16'hBEEF);
    run_op(2'd0, 2'd1, 4'd10, 16'hFFF0, c, f);
    check("R1 wrapped address", {16'h0, log_addr[f]}, 32'h0000_0004);
    check("R1 operand", operand, 32'h0000_BEEF);
  endtask

  task automatic t_indirect;
    int c, f;
    setw(16'h8304, 16'hA010);
    setw(16'hA010, 16'h5A5A);
    run_op(2'd1, 2'd1, 4'd2, 16'h8300, c, f);
    check("R3 operand", operand, 32'h0000_5A5A);
    check("R3 access count", log_n - f, 2);
    check("R3 no write", {30'b0, log_we[f], log_we[f+1]}, 32'h0);
    check("R3 register kept", {16'h0, getw(16'h8304)}, 32'h0000_A010);
    // reserved mode 3 behaves as indirect
    run_op(2'd3, 2'd1, 4'd2, 16'h8300, c, f);
    check("R2 mode3 as indirect", operand, 32'h0000_5A5A);
    check("R2 mode3 count", log_n - f, 2);
  endtask

  task automatic t_self_point;
    int c, f;
    setw(16'h8300, 16'h8300);
    run_op(2'd2, 2'd1, 4'd0, 16'h8300, c, f);
    check("R5 operand", operand, 32'h0000_8302);
    check("R5 register", {16'h0, getw(16'h8300)}, 32'h0000_8302);
    check("R4 step1 read reg", {15'b0, log_we[f], log_addr[f]}, {16'h0, 16'h8300});
    check("R4 step2 write reg", {15'b0, log_we[f+1], log_addr[f+1]}, {15'b0, 1'b1, 16'h8300});
    check("R4 step2 data", {16'h0, log_data[f+1]}, 32'h0000_8302);
    check("R4 step3 read op", {15'b0, log_we[f+2], log_addr[f+2]}, {16'h0, 16'h8300});
  endtask

  task automatic t_bytes;
    int c, f;
    setw(16'h8308, 16'hA021);
    setw(16'hA020, 16'h3C7E);
    run_op(2'd2, 2'd0, 4'd4, 16'h8300, c, f);
    check("R7 odd lane", operand, 32'h0000_007E);
    check("R6 byte increment", {16'h0, getw(16'h8308)}, 32'h0000_A022);
    check("R7 aligned read", {16'h0, log_addr[f+2]}, 32'h0000_A020);
    setw(16'h830A, 16'hA020);
    run_op(2'd2, 2'd0, 4'd5, 16'h8300, c, f);
    check("R7 even lane", operand, 32'h0000_003C);
    check("R6 byte increment even", {16'h0, getw(16'h830A)}, 32'h0000_A021);
  endtask

  task automatic t_wait_states;
    int c, f;
    setw(16'h830C, 16'hA030);
    setw(16'hA030, 16'h1111);
    lat = 0;
    run_op(2'd2, 2'd1, 4'd6, 16'h8300, c, f);
    check("R9 latency L0", c, 4);
    check("R6 word increment", {16'h0, getw(16'h830C)}, 32'h0000_A032);
    setw(16'h830C, 16'hA030);
    lat = 3;
    run_op(2'd2, 2'd1, 4'd6, 16'h8300, c, f);
    check("R9 latency L3", c, 13);
    check("R9 operand", operand, 32'h0000_1111);
    lat = 0;
  endtask

  task automatic t_dword;
    int c, f;
    setw(16'h831E, 16'h0000);
    setw(16'h8320, 16'h1000);
    setw(16'h8300, 16'h0012);
    run_op(2'd0, 2'd2, 4'd15, 16'h8300, c, f);
    check("R8 r15 operand", operand, 32'h0000_1000);
    check("R8 second addr", {16'h0, log_addr[f+1]}, 32'h0000_8320);
    setw(16'h830E, 16'hA040);
    setw(16'hA040, 16'hDEAD);
    setw(16'hA042, 16'hBEEF);
    run_op(2'd2, 2'd2, 4'd7, 16'h8300, c, f);
    check("R8 indirect dword", operand, 32'hDEAD_BEEF);
    check("R6 dword increment", {16'h0, getw(16'h830E)}, 32'h0000_A044);
  endtask

  task automatic t_busy_start;
    int c, dn;
    logic [31:0] held;
    setw(16'h8306, 16'h4321);
    setw(16'h8308, 16'h9999);
    lat = 3;
    @(negedge clk);
    mode = 2'd0; size = 2'd1; reg_idx = 4'd3; wp = 16'h8300; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    reg_idx = 4'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dn = 0;
    c = 0;
    while (!done && c < 100) begin @(negedge clk); c++; end
    held = operand;
    check("R10 first fetch kept", operand, 32'h0000_4321);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (done) dn++;
    end
    check("R10 done one cycle, no second fetch", dn, 0);
    check("R10 operand held", operand, held);
    lat = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_direct_word();
    t_wrap();
    t_indirect();
    t_self_point();
    t_bytes();
    t_wait_states();
    t_dword();
    t_busy_start();
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule